// File: doc/BRIEF.md
# Deadline-Aware DMA Channel Arbiter

This block decides, once per clock, which of up to sixteen requesting DMA channels is serviced next. Every channel belongs to one of four ports through a static configuration field and carries a time-to-deadline value. The decision uses three keys in strict order. The first key is the port, and the favoured port advances by one on every clock. The second key is an urgency group taken from the top bits of the deadline value. The third key is the channel index, with a per-port round-robin refresh after each grant.

If the favoured port has no requester, the choice moves to the next port in rotation order. A pending request therefore never goes without a grant. The result is registered and appears as a one-hot grant vector with a valid strobe. The port count is expected to be a power of two.

Top module: `dl_chan_arb`

## Requirements
- R1: While reset is asserted, and right after it, `grant_o` is all zero and `grant_vld_o` is low.
- R2: The grant is registered. The outputs after a rising edge reflect the inputs sampled at that edge. At most one bit of `grant_o` is set, and `grant_vld_o` is high exactly when a bit is set. A granted channel was requesting at that edge.
- R3: If no `req_i` bit is set at an edge, `grant_vld_o` is low and `grant_o` is zero after that edge.
- R4: A favoured-port counter is 0 at the first edge after reset release. It then rises by one (mod 4) at every edge, whether or not a grant is made. A requester on the favoured port wins over requesters on any other port, however urgent they are.
- R5: If the favoured port has no requester, the winning port is the first one with a requester when counting upward from the favoured port with wrap-around.
- R6: The urgency group of a channel is bits [15:14] of its deadline value, and a smaller group value is more urgent. Within the winning port, only channels of the smallest group present compete.
- R7: Among tied channels of a port that has had no grant since reset, the lowest channel index wins.
- R8: Each port remembers the channel it granted last. Among tied channels, the lowest index above that channel wins. If no tied channel has a higher index, the lowest index among the tied channels wins.
- R9: Channel c takes its port from `port_map_i[2c+1:2c]` and its deadline value from `ttd_i[16c+15:16c]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Per-channel request bits |
| port_map_i | input | 32 | Per-channel 2-bit port assignment |
| ttd_i | input | 256 | Per-channel 16-bit time-to-deadline |
| grant_o | output | 16 | One-hot registered grant |
| grant_vld_o | output | 1 | High when grant_o holds a grant |

## Verification
Every result of this arbiter is due exactly one clock edge after its inputs are applied. This covers the grant, the valid strobe and the effect of the favoured port. The driver applies the stimulus on a falling edge. It computes the expected grant for the favoured port of the next rising edge and tags the queued item with that edge number. The monitor counts rising edges after reset release and samples shortly after each one. It compares only items whose edge number matches, so no check can slip by a cycle.

// File: rtl/dl_arb_pkg.sv
package dl_arb_pkg;
  parameter int unsigned DEF_NCH   = 16;
  parameter int unsigned DEF_NPORT = 4;
  parameter int unsigned DEF_TTD_W = 16;
  parameter int unsigned DEF_GRP_W = 2;
endpackage

// File: rtl/arb_port_ring.sv
module arb_port_ring #(
  parameter int unsigned NPORT  = 4,
  localparam int unsigned PORT_W = $clog2(NPORT)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PORT_W-1:0] fav_o
);
  logic [PORT_W-1:0] fav_q, fav_d;

  always_comb begin
    fav_d = fav_q + PORT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fav_q <= '0;
    else        fav_q <= fav_d;
  end

  assign fav_o = fav_q;

  // R4
  fav_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fav_q == $past(fav_q) + PORT_W'(1));
endmodule

// File: rtl/arb_cand_filter.sv
module arb_cand_filter #(
  parameter int unsigned NCH   = 16,
  parameter int unsigned NPORT = 4,
  parameter int unsigned TTD_W = 16,
  parameter int unsigned GRP_W = 2,
  localparam int unsigned PORT_W = $clog2(NPORT)
) (
  input  logic [NCH-1:0]        req_i,
  input  logic [NCH*PORT_W-1:0] port_map_i,
  input  logic [NCH*TTD_W-1:0]  ttd_i,
  input  logic [PORT_W-1:0]     fav_i,
  output logic [NCH-1:0]        cand_o,
  output logic [PORT_W-1:0]     sel_port_o,
  output logic                  any_o
);
  logic [NPORT-1:0]  port_has;
  logic [PORT_W-1:0] ch_port [NCH];
  logic [GRP_W-1:0]  ch_grp  [NCH];
  logic [NCH-1:0]    in_port;
  logic [GRP_W-1:0]  min_grp;
  logic [PORT_W-1:0] idx;
  logic              found;

  for (genvar c = 0; c < NCH; c++) begin : g_fields
    assign ch_port[c] = port_map_i[c*PORT_W +: PORT_W];
    assign ch_grp[c]  = ttd_i[c*TTD_W + TTD_W - GRP_W +: GRP_W];
  end

  always_comb begin
    port_has = '0;
    for (int c = 0; c < NCH; c++) begin
      if (req_i[c]) port_has[ch_port[c]] = 1'b1;
    end
    sel_port_o = fav_i;
    found      = 1'b0;
    idx        = '0;
    for (int k = 0; k < NPORT; k++) begin
      idx = fav_i + PORT_W'(k);
      if (!found && port_has[idx]) begin
        sel_port_o = idx;
        found      = 1'b1;
      end
    end
    min_grp = '1;
    for (int c = 0; c < NCH; c++) begin
      in_port[c] = req_i[c] && (ch_port[c] == sel_port_o);
      if (in_port[c] && ch_grp[c] < min_grp) min_grp = ch_grp[c];
    end
    for (int c = 0; c < NCH; c++) begin
      cand_o[c] = in_port[c] && (ch_grp[c] == min_grp);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned NCH   = 16,
  parameter int unsigned NPORT = 4,
  localparam int unsigned PORT_W = $clog2(NPORT),
  localparam int unsigned CH_W   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cand_i,
  input  logic [PORT_W-1:0] sel_port_i,
  input  logic              any_i,
  output logic [NCH-1:0]    win_o
);
  logic [CH_W-1:0]  last_q [NPORT];
  logic [CH_W-1:0]  last_d [NPORT];
  logic [NPORT-1:0] lv_q, lv_d;
  logic [NCH-1:0]   upper, pool;
  logic [CH_W-1:0]  win_idx;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      upper[c] = cand_i[c] &&
                 (!lv_q[sel_port_i] || (CH_W'(c) > last_q[sel_port_i]));
    end
    pool  = (|upper) ? upper : cand_i;
    win_o = pool & (~pool + NCH'(1));
    win_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      if (win_o[c]) win_idx = CH_W'(c);
    end
    last_d = last_q;
    lv_d   = lv_q;
    if (any_i) begin
      last_d[sel_port_i] = win_idx;
      lv_d[sel_port_i]   = 1'b1;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q[p] <= '0;
        lv_q[p]   <= 1'b0;
      end else if (any_i) begin
        last_q[p] <= last_d[p];
        lv_q[p]   <= lv_d[p];
      end
    end
  end

  // R2
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_i |-> $onehot(win_o));
  // R8
  pick_in_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o & ~cand_i) == '0);
endmodule

// File: rtl/dl_chan_arb.sv
module dl_chan_arb
  import dl_arb_pkg::*;
#(
  parameter int unsigned NCH   = DEF_NCH,
  parameter int unsigned NPORT = DEF_NPORT,
  parameter int unsigned TTD_W = DEF_TTD_W,
  parameter int unsigned GRP_W = DEF_GRP_W,
  localparam int unsigned PORT_W = $clog2(NPORT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        req_i,
  input  logic [NCH*PORT_W-1:0] port_map_i,
  input  logic [NCH*TTD_W-1:0]  ttd_i,
  output logic [NCH-1:0]        grant_o,
  output logic                  grant_vld_o
);
  logic [PORT_W-1:0] fav;
  logic [PORT_W-1:0] sel_port;
  logic [NCH-1:0]    cand, win;
  logic              any_req;
  logic [NCH-1:0]    grant_q, grant_d;
  logic              vld_q, vld_d;

  arb_port_ring #(.NPORT(NPORT)) u_ring (
    .clk(clk), .rst_n(rst_n), .fav_o(fav)
  );

  arb_cand_filter #(.NCH(NCH), .NPORT(NPORT), .TTD_W(TTD_W), .GRP_W(GRP_W)) u_filt (
    .req_i(req_i), .port_map_i(port_map_i), .ttd_i(ttd_i), .fav_i(fav),
    .cand_o(cand), .sel_port_o(sel_port), .any_o(any_req)
  );

  arb_rr_pick #(.NCH(NCH), .NPORT(NPORT)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand_i(cand), .sel_port_i(sel_port),
    .any_i(any_req), .win_o(win)
  );

  always_comb begin
    grant_d = any_req ? win : '0;
    vld_d   = any_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      vld_q   <= vld_d;
    end
  end

  assign grant_o     = grant_q;
  assign grant_vld_o = vld_q;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R2
  vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o == (grant_o != '0));
  // R3
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> !grant_vld_o);
  // R5
  no_lost_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> grant_vld_o);
  // R2
  grant_was_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> ((grant_o & $past(req_i)) != '0));
endmodule

// File: tb/dl_chan_arb_tb_top.sv
`timescale 1ns/1ps
module dl_chan_arb_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  req;
  logic [31:0]  pmap;
  logic [255:0] ttd;
  logic [15:0]  grant;
  logic         vld;

  typedef struct {
    logic        v;
    logic [15:0] g;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  logic [3:0] m_last [4];
  logic [3:0] m_lv;

  always #2 clk = ~clk;

  dl_chan_arb dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .port_map_i(pmap), .ttd_i(ttd),
    .grant_o(grant), .grant_vld_o(vld)
  );

  task automatic model(input logic [15:0] r, input logic [31:0] m,
                       input logic [255:0] t, input int fav,
                       output logic v, output logic [15:0] g);
    logic [3:0] has;
    int sel, mg, w;
    logic [15:0] cnd, up;
    has = '0;
    for (int c = 0; c < 16; c++) if (r[c]) has[m[2*c +: 2]] = 1'b1;
    sel = -1;
    for (int k = 0; k < 4; k++) if (sel < 0 && has[(fav + k) % 4]) sel = (fav + k) % 4;
    g = '0;
    v = (r != 0);
    if (!v) return;
    mg = 4;
    for (int c = 0; c < 16; c++)
      if (r[c] && m[2*c +: 2] == sel && int'(t[16*c+14 +: 2]) < mg) mg = int'(t[16*c+14 +: 2]);
    cnd = '0;
    up  = '0;
    for (int c = 0; c < 16; c++) begin
      cnd[c] = r[c] && m[2*c +: 2] == sel && int'(t[16*c+14 +: 2]) == mg;
      up[c]  = cnd[c] && (!m_lv[sel] || c > int'(m_last[sel]));
    end
    if (up == 0) up = cnd;
    w = -1;
    for (int c = 0; c < 16; c++) if (w < 0 && up[c]) w = c;
    g[w] = 1'b1;
    m_last[sel] = 4'(w);
    m_lv[sel] = 1'b1;
  endtask

  task automatic drive(input logic [15:0] r, input logic [31:0] m,
                       input logic [255:0] t, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; pmap = m; ttd = t;
    model(r, m, t, cyc % 4, e.v, e.g);
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      cyc++;
      while (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (vld !== e.v || grant !== e.g) begin
          fails++;
          $display("FAIL %s: got vld=%0b grant=%h, expected vld=%0b grant=%h",
                   e.tag, vld, grant, e.v, e.g);
        end
      end
    end
  end

  function automatic logic [31:0] all_port(input logic [1:0] p);
    logic [31:0] m;
    for (int c = 0; c < 16; c++) m[2*c +: 2] = p;
    return m;
  endfunction

  function automatic logic [255:0] all_grp(input logic [1:0] gr);
    logic [255:0] t;
    for (int c = 0; c < 16; c++) t[16*c +: 16] = {gr, 14'h0123};
    return t;
  endfunction

  initial begin
    logic [31:0]  m;
    logic [255:0] t;
    rst_n = 1'b0; req = '0; pmap = '0; ttd = '0;
    m_lv = '0;
    for (int p = 0; p < 4; p++) m_last[p] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== '0 || vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: got vld=%0b grant=%h, expected vld=0 grant=0000", vld, grant);
    end
    rst_n = 1'b1;
    // R3 idle
    drive(16'h0000, '0, '0, "R3");
    drive(16'h0000, '0, '0, "R3");
    // R7 fresh tie on port 2, group 0
    drive(16'h0A50, all_port(2'd2), all_grp(2'd0), "R7");
    // R8 repeated tie rotates within port 2
    drive(16'h0A50, all_port(2'd2), all_grp(2'd0), "R8");
    drive(16'h0A50, all_port(2'd2), all_grp(2'd0), "R8");
    drive(16'h0A50, all_port(2'd2), all_grp(2'd0), "R8");
    drive(16'h0A50, all_port(2'd2), all_grp(2'd0), "R8");
    // R6 group: ch 9 group 1 beats ch 2 group 2 and ch 4 group 3 on port 0
    t = all_grp(2'd3);
    t[16*9+14 +: 2] = 2'd1;
    t[16*2+14 +: 2] = 2'd2;
    drive(16'h0214, all_port(2'd0), t, "R6");
    drive(16'h0214, all_port(2'd0), t, "R6");
    // R9 single requester on each port in turn
    for (int c = 0; c < 16; c += 5) begin
      m = '0;
      m[2*c +: 2] = 2'(c % 4);
      drive(16'(1) << c, m, all_grp(2'd2), "R9");
    end
    // R4 one urgent channel per port, favoured port decides
    m = '0;
    m[0 +: 2] = 2'd0; m[2 +: 2] = 2'd1; m[4 +: 2] = 2'd2; m[6 +: 2] = 2'd3;
    t = all_grp(2'd3);
    t[16*3+14 +: 2] = 2'd0;
    for (int i = 0; i < 8; i++) drive(16'h000F, m, t, "R4");
    // R5 only ports 1 and 3 requesting
    m = '0;
    m[2*5 +: 2] = 2'd1; m[2*11 +: 2] = 2'd3;
    for (int i = 0; i < 8; i++) drive(16'h0820, m, all_grp(2'd1), "R5");
    // R2 mixed stress
    for (int i = 0; i < 400; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      if (i % 7 == 0) r = '0;
      if (i % 5 == 0) r = r & 16'h0101;
      for (int k = 0; k < 8; k++) t[32*k +: 32] = $urandom;
      drive(r, $urandom, t, "R2");
    end
    drive(16'h0000, '0, '0, "R3");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin
        #40000;
        if (!done) begin
          fails++;
          checks++;
          $display("FAIL watchdog: got run still active, expected completion");
        end
      end
      wait (done);
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule